// File: doc/BRIEF.md
# Serial Sample Capture and Similarity Scoring Engine

This block records a short fingerprint of an audio stream and later measures how closely a second stream matches it. After reset it waits in a setup mode until the codec configuration logic reports that it is done, and then it rests in an idle mode. A store switch starts a recording run. In that run, each sample tick flips the left/right channel select line, and the next clock takes the most significant bit of the new sample from the serial ADC data line. That bit goes into a DEPTH-bit register at the position given by the sample index.

A compare switch starts a scoring run. It uses the same tick, channel alternation and capture timing. Each captured bit is checked against the bit stored at the same index. The score is preset to DEPTH at the start of the run and loses one for every mismatch, so the final value is the number of matching positions. A run of either kind stops by itself after DEPTH samples and returns to idle. The channel select, the mode, the index and the score are all visible at the ports, so a display or controller can follow progress while a run is in progress.

Top module: `smpl_match_core`

## Requirements
- R1: While reset is asserted and right after it, mode is setup (code 0), the index is 0, the score equals DEPTH and the channel select is 0.
- R2: In setup, the switches and ticks have no effect. The clock edge that samples configuration-done high moves the mode to idle (code 1).
- R3: In idle, a store switch sampled high moves the mode to store (code 2) at the next edge and clears the index. Store wins when both switches are high.
- R4: In idle, with the store switch low, a compare switch sampled high moves the mode to compare (code 3), clears the index and presets the score to DEPTH.
- R5: In store or compare, each clock edge that samples the tick high inverts the channel select. Ticks in setup or idle leave it unchanged.
- R6: The ADC data bit is captured at the first clock edge after the edge that toggled the channel select, and that same edge advances the index by one.
- R7: In store, the captured bit is written to the register position equal to the index before it advances.
- R8: In compare, a captured bit that differs from the stored bit at the current index lowers the score by one. A matching bit leaves it unchanged. The score never rises during a run.
- R9: The edge that takes the DEPTH-th sample of a run returns the mode to idle and leaves the index at DEPTH.
- R10: Switch changes during a store or compare run have no effect on the mode or the index.
- R11: The score holds its last value in idle and through a store run, until the next compare run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | One-cycle strobe requesting the next sample |
| adc_bit | input | 1 | Serial ADC data line; its first bit after a channel switch is the sample MSB |
| cfg_done | input | 1 | Codec configuration finished |
| store_sw | input | 1 | Request a recording run |
| cmp_sw | input | 1 | Request a scoring run |
| lr_sel | output | 1 | Left/right channel select sent to the converter |
| mode_o | output | 2 | Mode: 0 setup, 1 idle, 2 store, 3 compare |
| smp_idx | output | $clog2(DEPTH+1) | Sample index, 0 to DEPTH |
| match_score | output | $clog2(DEPTH+1) | Number of matching positions, counted down from DEPTH |

## Verification
The bench builds the block with its default DEPTH of 100. With that value a full run reaches the terminal index of 100. The score can be driven to exactly 100 by an identical replay, to an intermediate value by a partly flipped replay, and down to 0 by a fully inverted replay, so the bottom of the score range is reached without any underflow. At the same depth, switch toggles can be placed well inside long runs, and store and compare runs can be chained so that the score is seen holding across a later recording.

// File: rtl/smc_pkg.sv
package smc_pkg;
   typedef enum logic [1:0] {
      SMC_SETUP = 2'd0,
      SMC_IDLE  = 2'd1,
      SMC_STORE = 2'd2,
      SMC_CMP   = 2'd3
   } smc_mode_e;
endpackage

// File: rtl/smc_lane_sel.sv
// Channel alternation and capture strobe: a tick in a run flips the lane,
// and the following cycle is the first bit slot of the new sample word.
module smc_lane_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic smp_tick,
   output logic lr_sel,
   output logic sample_now
);
   logic take;
   assign take = run & smp_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_sel     <= 1'b0;
         sample_now <= 1'b0;
      end else begin
         lr_sel     <= lr_sel ^ take;
         sample_now <= take;
      end
   end

   // R5
   lane_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && smp_tick) |=> (lr_sel != $past(lr_sel)));
   // R5
   lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && smp_tick) |=> $stable(lr_sel));
endmodule

// File: rtl/smc_bit_store.sv
// DEPTH-bit sample register with one-hot write and mux-free read.
module smc_bit_store #(
   parameter int DEPTH = 100,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic             din,
   output logic             dout
);
   logic [DEPTH-1:0] bits_q;
   logic [DEPTH-1:0] hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic sel;
      assign sel    = (idx == IDX_W'(i));
      assign hit[i] = sel & bits_q[i];
      always_ff @(posedge clk) begin
         if (!rst_n)
            bits_q[i] <= 1'b0;
         else if (we && sel)
            bits_q[i] <= din;
      end
   end

   assign dout = |hit;

   // R7
   store_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/smc_score.sv
// Match counter: preset to DEPTH, loses one per mismatch.
module smc_score #(
   parameter int DEPTH = 100,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             miss,
   output logic [IDX_W-1:0] score
);
   localparam logic [IDX_W-1:0] FULL = IDX_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n)
         score <= FULL;
      else if (clear)
         score <= FULL;
      else if (miss && score != '0)
         score <= score - 1'b1;
   end

   // R8
   score_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (score == $past(score) || score == $past(score) - 1'b1));
   // R4
   score_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (score == FULL));
endmodule

// File: rtl/smc_mode_fsm.sv
// Mode sequencer and sample index.
module smc_mode_fsm
   import smc_pkg::*;
#(
   parameter int DEPTH = 100,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_done,
   input  logic             store_sw,
   input  logic             cmp_sw,
   input  logic             sample_now,
   output smc_mode_e        mode,
   output logic [IDX_W-1:0] idx,
   output logic             run,
   output logic             cmp_start
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   smc_mode_e        mode_n;
   logic [IDX_W-1:0] idx_n;
   logic             in_idle;

   assign run       = (mode == SMC_STORE) || (mode == SMC_CMP);
   assign in_idle   = (mode == SMC_IDLE);
   assign cmp_start = in_idle && !store_sw && cmp_sw;

   always_comb begin
      mode_n = mode;
      idx_n  = idx;
      unique case (mode)
         SMC_SETUP: if (cfg_done) mode_n = SMC_IDLE;
         SMC_IDLE: begin
            if (store_sw) begin
               mode_n = SMC_STORE;
               idx_n  = '0;
            end else if (cmp_sw) begin
               mode_n = SMC_CMP;
               idx_n  = '0;
            end
         end
         default: begin
            if (sample_now) begin
               idx_n = idx + 1'b1;
               if (idx == LAST) mode_n = SMC_IDLE;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= SMC_SETUP;
         idx  <= '0;
      end else begin
         mode <= mode_n;
         idx  <= idx_n;
      end
   end

   // R2
   setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SMC_SETUP && !cfg_done) |=> (mode == SMC_SETUP));
   // R3
   store_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SMC_IDLE && store_sw) |=> (mode == SMC_STORE && idx == '0));
   // R10
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !sample_now) |=> ($stable(mode) && $stable(idx)));
   // R9
   idx_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_W'(DEPTH));
endmodule

// File: rtl/smpl_match_core.sv
module smpl_match_core
   import smc_pkg::*;
#(
   parameter int DEPTH = 100,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_tick,
   input  logic             adc_bit,
   input  logic             cfg_done,
   input  logic             store_sw,
   input  logic             cmp_sw,
   output logic             lr_sel,
   output logic [1:0]       mode_o,
   output logic [IDX_W-1:0] smp_idx,
   output logic [IDX_W-1:0] match_score
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("smpl_match_core: DEPTH must be at least 2");
   end

   smc_mode_e mode;
   logic      run, cmp_start, sample_now, stored_bit;
   logic      wr_en, miss;

   smc_lane_sel u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .smp_tick  (smp_tick),
      .lr_sel    (lr_sel),
      .sample_now(sample_now)
   );

   smc_mode_fsm #(.DEPTH(DEPTH)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_done  (cfg_done),
      .store_sw  (store_sw),
      .cmp_sw    (cmp_sw),
      .sample_now(sample_now),
      .mode      (mode),
      .idx       (smp_idx),
      .run       (run),
      .cmp_start (cmp_start)
   );

   assign wr_en = sample_now && (mode == SMC_STORE);
   assign miss  = sample_now && (mode == SMC_CMP) && (adc_bit != stored_bit);

   smc_bit_store #(.DEPTH(DEPTH)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en),
      .idx  (smp_idx),
      .din  (adc_bit),
      .dout (stored_bit)
   );

   smc_score #(.DEPTH(DEPTH)) u_score (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(cmp_start),
      .miss (miss),
      .score(match_score)
   );

   assign mode_o = mode;

   // R11
   score_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SMC_CMP && !cmp_start) |=> $stable(match_score));
endmodule

// File: tb/smpl_match_core_bench.sv
`timescale 1ns/1ps
module smpl_match_core_bench;
   localparam int DEPTH = 100;
   localparam int IDX_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_tick = 1'b0, adc_bit = 1'b0, cfg_done = 1'b0;
   logic store_sw = 1'b0, cmp_sw = 1'b0;
   logic             lr_sel;
   logic [1:0]       mode_o;
   logic [IDX_W-1:0] smp_idx, match_score;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   int m_mode, m_idx, m_score;
   bit m_lr, m_pend;
   bit m_mem[DEPTH];

   smpl_match_core #(.DEPTH(DEPTH)) u_smpl_match_core (
      .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .adc_bit(adc_bit),
      .cfg_done(cfg_done), .store_sw(store_sw), .cmp_sw(cmp_sw),
      .lr_sel(lr_sel), .mode_o(mode_o), .smp_idx(smp_idx),
      .match_score(match_score)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
      end
   endtask

   task automatic model_update();
      bit run, b;
      if (!rst_n) begin
         m_mode = 0; m_idx = 0; m_score = DEPTH; m_lr = 0; m_pend = 0;
         foreach (m_mem[i]) m_mem[i] = 0;
         return;
      end
      run = (m_mode == 2) || (m_mode == 3);
      case (m_mode)
         0: if (cfg_done) m_mode = 1;
         1: begin
            if (store_sw) begin m_mode = 2; m_idx = 0; end
            else if (cmp_sw) begin m_mode = 3; m_idx = 0; m_score = DEPTH; end
         end
         default: if (m_pend) begin
            b = adc_bit;
            if (m_mode == 2) m_mem[m_idx] = b;
            else if (b != m_mem[m_idx]) m_score--;
            m_idx++;
            if (m_idx == DEPTH) m_mode = 1;
         end
      endcase
      if (run && smp_tick) m_lr = !m_lr;
      m_pend = run && smp_tick;
   endtask

   task automatic compare_all();
      check("R9 mode", int'(mode_o), m_mode);
      check("R6 index", int'(smp_idx), m_idx);
      check("R8 score", int'(match_score), m_score);
      check("R5 lane", int'(lr_sel), int'(m_lr));
   endtask

   task automatic step(input bit t, input bit d, input bit s, input bit c, input bit f);
      smp_tick = t; adc_bit = d; store_sw = s; cmp_sw = c; cfg_done = f;
      @(posedge clk);
      cycles++;
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   function automatic bit pat_a(input int i);
      return ((i * 7 + 3) % 5) < 2;
   endfunction

   // one full run; flip_every>0 inverts bits at indices divisible by it
   task automatic do_run(input bit st, input int flip_every, input bit invert_all,
                         input bit poke_sw);
      bit b;
      step(0, 0, st, !st, 1);  // leave idle
      for (int i = 0; i < DEPTH; i++) begin
         b = pat_a(i);
         if (invert_all) b = !b;
         else if (flip_every > 0 && (i % flip_every) == 0) b = !b;
         // R10: switches wiggle mid-run when requested
         step(1, b, poke_sw && (i == 40), poke_sw && (i == 60), 1);
         step(0, b, 0, 0, 1);
         step(0, !b, 0, 0, 1);
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual cycles %0d expected below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      @(negedge clk);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      rst_n = 1'b1;
      // R1: reset state at the ports
      check("R1 mode", int'(mode_o), 0);
      check("R1 index", int'(smp_idx), 0);
      check("R1 score", int'(match_score), DEPTH);
      check("R1 lane", int'(lr_sel), 0);
      // R2: switches and ticks ignored in setup
      step(1, 1, 1, 1, 0);
      step(1, 0, 1, 0, 0);
      check("R2 setup held", int'(mode_o), 0);
      step(0, 0, 0, 0, 1);
      check("R2 to idle", int'(mode_o), 1);
      // R5: ticks in idle leave lane alone
      step(1, 1, 0, 0, 1);
      step(0, 0, 0, 0, 1);
      check("R5 idle lane", int'(lr_sel), 0);
      // R3: both switches -> store wins
      step(0, 0, 1, 1, 1);
      check("R3 store priority", int'(mode_o), 2);
      check("R3 index cleared", int'(smp_idx), 0);
      // R6: capture one cycle after toggle
      step(1, 1, 0, 0, 1);
      check("R5 toggle", int'(lr_sel), 1);
      check("R6 idx before capture", int'(smp_idx), 0);
      step(0, 1, 0, 0, 1);
      check("R6 idx after capture", int'(smp_idx), 1);
      // finish this store run with pattern from index 1
      for (int i = 1; i < DEPTH; i++) begin
         step(1, pat_a(i), (i == 50), (i == 50), 1);  // R10
         step(0, pat_a(i), 0, 0, 1);
         step(0, 0, 0, 0, 1);
      end
      // R9: end of run
      check("R9 back to idle", int'(mode_o), 1);
      check("R9 index at depth", int'(smp_idx), DEPTH);
      // R4 / R7 / R8: identical replay, bit 0 was stored as 1
      do_run(0, 0, 0, 1);
      check("R7 identical replay", int'(match_score), DEPTH - (pat_a(0) ? 0 : 1));
      // store clean pattern A, then partly flipped compare
      do_run(1, 0, 0, 1);
      check("R11 score kept over store", int'(match_score), DEPTH - (pat_a(0) ? 0 : 1));
      do_run(0, 8, 0, 0);
      check("R8 partial mismatch", int'(match_score), DEPTH - 13);
      do_run(0, 0, 0, 0);
      check("R7 full match", int'(match_score), DEPTH);
      do_run(0, 0, 1, 0);
      check("R8 full mismatch", int'(match_score), 0);
      // R11: idle hold with ticks and stray compare-free cycles
      step(1, 1, 0, 0, 1);
      step(0, 0, 0, 0, 1);
      check("R11 idle hold", int'(match_score), 0);
      // R4: compare entry presets score
      step(0, 0, 0, 1, 1);
      check("R4 compare mode", int'(mode_o), 3);
      check("R4 score preset", int'(match_score), DEPTH);
      check("R4 index cleared", int'(smp_idx), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule